// File: doc/BRIEF.md
# Cascaded Two-Level Interrupt Controller

This block collects interrupt requests from three 8-bit source groups and two timer lines and presents them to a processor as two level-sensitive interrupt outputs. Two local groups each own a status word and an enable mask. A third, shared group of secondary sources has one status word and two independent enable masks. The qualified result of each of those masks folds back into one fixed bit of a local group. This gives a two-level tree that software walks from a local output down to the secondary source.

Every external request passes through a two-flop synchronizer before it is reported. The two timer lines are caught on their rising edge and held in sticky pending bits that occupy two positions of local group 1. Software clears them by writing ones to a timer clear register. All registers sit behind a simple 32-bit word interface. Reads are combinational and writes take one clock.

Top module: `casc_irq_ctrl`

## Requirements
- R1: After reset all four mask registers read 0, both interrupt outputs are low and the timer pending bits (timer register bits [1:0]) read 0.
- R2: Word registers are at byte offsets 0x00 local0 status, 0x04 local0 mask, 0x08 local1 status, 0x0C local1 mask, 0x10 shared status, 0x14 shared mask A, 0x18 shared mask B, 0x1C timer register. Bits [31:8] always read 0, and any offset from 0x20 up reads 0 and ignores writes.
- R3: Local and shared status registers report their synchronized source inputs unmasked. A source change is visible on the second rising clock edge after it is driven.
- R4: `irq_out0` is a register loaded on each clock with the OR of (local0 status AND local0 mask). It rises on the clock edge after a qualifying status or mask change.
- R5: `irq_out1` behaves the same way for local1 status and the local1 mask.
- R6: Local0 status bit 7 is the OR of (shared status AND shared mask A), and the external local0 source bit 7 has no effect.
- R7: Local1 status bit 3 is the OR of (shared status AND shared mask B), and it is independent of shared mask A. The external local1 source bit 3 has no effect.
- R8: A rising edge on timer line i sets pending bit i, shown in timer register bit i and local1 status bit i. It stays set while the line is high or low, until cleared, and external local1 source bits 0 and 1 have no effect.
- R9: Writing the timer register clears each pending bit whose data bit is 1 and leaves the others. Writing 0x03 clears both, and a line held high does not set its pending bit again.
- R10: Writes to the three status offsets change no register.
- R11: Each mask register reads back the low 8 bits last written, so read-modify-write works, and writing 0 disables every source under it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loc0_src | input | 8 | Local group 0 request lines |
| loc1_src | input | 8 | Local group 1 request lines |
| map_src | input | 8 | Shared secondary request lines |
| tmr_src | input | 2 | Timer request lines, edge detected |
| bus_addr | input | 6 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_out0 | output | 1 | Interrupt output for local group 0 |
| irq_out1 | output | 1 | Interrupt output for local group 1 |

## Verification
The bench checks that the cascade bits follow only their own shared mask. A design that swapped or merged the two shared masks would raise local1 bit 3 when only mask A enables a source. It also checks that an external request on a cascade or timer bit position never leaks into a status word, and that a timer line held high after a clear does not set its bit again, which a level-latched design would do. It measures the exact latency of the synchronizer and output register, confirms that status and out-of-range writes leave every mask untouched, and checks that a partial timer clear leaves the other bit pending.

// File: rtl/casc_irq_pkg.sv
`timescale 1ns/1ps
package casc_irq_pkg;
   // word index of each register (byte offset / 4)
   typedef enum logic [2:0] {
      RIX_L0_STAT  = 3'd0,
      RIX_L0_MASK  = 3'd1,
      RIX_L1_STAT  = 3'd2,
      RIX_L1_MASK  = 3'd3,
      RIX_SH_STAT  = 3'd4,
      RIX_SH_MASKA = 3'd5,
      RIX_SH_MASKB = 3'd6,
      RIX_TMR      = 3'd7
   } reg_idx_e;

   localparam int unsigned NUM_MASKS = 4;
   // slot of each mask in the mask array
   localparam int unsigned MSK_L0 = 0;
   localparam int unsigned MSK_L1 = 1;
   localparam int unsigned MSK_SA = 2;
   localparam int unsigned MSK_SB = 3;
endpackage

// File: rtl/irq_sync.sv
`timescale 1ns/1ps
module irq_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("irq_sync needs at least two stages");
   end
   if (W < 1) begin : g_bad_w
      $error("irq_sync width must be positive");
   end

   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg <= '0;
      end else begin
         stg[0] <= d;
         for (int s = 1; s < STAGES; s++) begin
            stg[s] <= stg[s-1];
         end
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/irq_rise_latch.sv
`timescale 1ns/1ps
module irq_rise_latch #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl,
   input  logic [N-1:0] clr,
   output logic [N-1:0] pend
);
   if (N < 1) begin : g_bad_n
      $error("irq_rise_latch needs at least one line");
   end

   logic [N-1:0] prev_q;
   logic [N-1:0] rise;

   assign rise = lvl & ~prev_q;

   for (genvar i = 0; i < N; i++) begin : g_line
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prev_q[i] <= 1'b0;
            pend[i]   <= 1'b0;
         end else begin
            prev_q[i] <= lvl[i];
            // a fresh edge wins over a clear in the same cycle
            pend[i]   <= rise[i] | (pend[i] & ~clr[i]);
         end
      end
   end
endmodule

// File: rtl/irq_mask_reg.sv
`timescale 1ns/1ps
module irq_mask_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= d;
   end
endmodule

// File: rtl/casc_irq_ctrl.sv
`timescale 1ns/1ps
module casc_irq_ctrl
   import casc_irq_pkg::*;
#(
   parameter int GRP_W       = 8,
   parameter int TMR_N       = 2,
   parameter int TMR_BASE    = 0,
   parameter int CASC0_POS   = 7,
   parameter int CASC1_POS   = 3,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 6,
   parameter int DATA_W      = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [GRP_W-1:0]  loc0_src,
   input  logic [GRP_W-1:0]  loc1_src,
   input  logic [GRP_W-1:0]  map_src,
   input  logic [TMR_N-1:0]  tmr_src,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_out0,
   output logic              irq_out1
);
   localparam int IDX_W = ADDR_W - 2;
   localparam int ALL_W = 3 * GRP_W + TMR_N;

   if (ADDR_W < 5) begin : g_bad_addr
      $error("address must cover eight words");
   end
   if (DATA_W < GRP_W) begin : g_bad_data
      $error("data bus narrower than a group");
   end
   if (CASC0_POS >= GRP_W || CASC1_POS >= GRP_W) begin : g_bad_casc
      $error("cascade position outside the group");
   end
   if (TMR_BASE + TMR_N > GRP_W) begin : g_bad_tmr
      $error("timer bits outside local group 1");
   end
   if (CASC1_POS >= TMR_BASE && CASC1_POS < TMR_BASE + TMR_N) begin : g_bad_overlap
      $error("cascade bit overlaps a timer bit");
   end

   // ---------------- synchronizers ----------------
   logic [ALL_W-1:0] sync_q;
   logic [GRP_W-1:0] l0_sync, l1_sync, map_stat;
   logic [TMR_N-1:0] tmr_sync;

   irq_sync #(.W(ALL_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({tmr_src, map_src, loc1_src, loc0_src}),
      .q     (sync_q)
   );

   assign l0_sync  = sync_q[GRP_W-1:0];
   assign l1_sync  = sync_q[2*GRP_W-1:GRP_W];
   assign map_stat = sync_q[3*GRP_W-1:2*GRP_W];
   assign tmr_sync = sync_q[ALL_W-1:3*GRP_W];

   // ---------------- register decode ----------------
   logic [IDX_W-1:0]     word;
   logic                 in_range;
   logic [NUM_MASKS-1:0] mask_we;
   logic [TMR_N-1:0]     tmr_clr;

   assign word     = bus_addr[ADDR_W-1:2];
   assign in_range = (int'(word) < 8);

   always_comb begin
      mask_we = '0;
      tmr_clr = '0;
      if (bus_wr && in_range) begin
         case (int'(word))
            int'(RIX_L0_MASK):  mask_we[MSK_L0] = 1'b1;
            int'(RIX_L1_MASK):  mask_we[MSK_L1] = 1'b1;
            int'(RIX_SH_MASKA): mask_we[MSK_SA] = 1'b1;
            int'(RIX_SH_MASKB): mask_we[MSK_SB] = 1'b1;
            int'(RIX_TMR):      tmr_clr = bus_wdata[TMR_N-1:0];
            default: ;
         endcase
      end
   end

   // ---------------- mask registers ----------------
   logic [NUM_MASKS-1:0][GRP_W-1:0] mask_q;

   for (genvar m = 0; m < NUM_MASKS; m++) begin : g_mask
      irq_mask_reg #(.W(GRP_W)) u_mask (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (mask_we[m]),
         .d     (bus_wdata[GRP_W-1:0]),
         .q     (mask_q[m])
      );
   end

   logic [GRP_W-1:0] l0_mask, l1_mask, map_mask0, map_mask1;
   assign l0_mask   = mask_q[MSK_L0];
   assign l1_mask   = mask_q[MSK_L1];
   assign map_mask0 = mask_q[MSK_SA];
   assign map_mask1 = mask_q[MSK_SB];

   // ---------------- timer edge latch ----------------
   logic [TMR_N-1:0] tmr_pend;

   irq_rise_latch #(.N(TMR_N)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (tmr_sync),
      .clr   (tmr_clr),
      .pend  (tmr_pend)
   );

   // ---------------- cascade and status views ----------------
   logic             casc0, casc1;
   logic [GRP_W-1:0] l0_view, l1_view;

   assign casc0 = |(map_stat & map_mask0);
   assign casc1 = |(map_stat & map_mask1);

   always_comb begin
      l0_view            = l0_sync;
      l0_view[CASC0_POS] = casc0;
   end

   always_comb begin
      l1_view = l1_sync;
      for (int t = 0; t < TMR_N; t++) begin
         l1_view[TMR_BASE + t] = tmr_pend[t];
      end
      l1_view[CASC1_POS] = casc1;
   end

   // ---------------- outputs ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_out0 <= 1'b0;
         irq_out1 <= 1'b0;
      end else begin
         irq_out0 <= |(l0_view & l0_mask);
         irq_out1 <= |(l1_view & l1_mask);
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (in_range) begin
         case (int'(word))
            int'(RIX_L0_STAT):  bus_rdata = DATA_W'(l0_view);
            int'(RIX_L0_MASK):  bus_rdata = DATA_W'(l0_mask);
            int'(RIX_L1_STAT):  bus_rdata = DATA_W'(l1_view);
            int'(RIX_L1_MASK):  bus_rdata = DATA_W'(l1_mask);
            int'(RIX_SH_STAT):  bus_rdata = DATA_W'(map_stat);
            int'(RIX_SH_MASKA): bus_rdata = DATA_W'(map_mask0);
            int'(RIX_SH_MASKB): bus_rdata = DATA_W'(map_mask1);
            int'(RIX_TMR):      bus_rdata = DATA_W'(tmr_pend);
            default:            bus_rdata = '0;
         endcase
      end
   end

   logic unused_bits;
   assign unused_bits = ^{bus_addr[1:0], bus_wdata};
endmodule

// File: rtl/casc_irq_ctrl_chk.sv
`timescale 1ns/1ps
module casc_irq_ctrl_chk #(
   parameter int GRP_W     = 8,
   parameter int TMR_N     = 2,
   parameter int CASC0_POS = 7,
   parameter int CASC1_POS = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             irq_out0,
   input logic             irq_out1,
   input logic [GRP_W-1:0] l0_view,
   input logic [GRP_W-1:0] l1_view,
   input logic [GRP_W-1:0] l0_mask,
   input logic [GRP_W-1:0] l1_mask,
   input logic [GRP_W-1:0] map_mask0,
   input logic [GRP_W-1:0] map_mask1,
   input logic [TMR_N-1:0] tmr_pend,
   input logic [TMR_N-1:0] tmr_clr
);
   assert_irq0_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (|(l0_view & l0_mask)) |=> irq_out0);
   assert_irq0_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(l0_view & l0_mask)) |=> !irq_out0);
   assert_irq1_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (|(l1_view & l1_mask)) |=> irq_out1);
   assert_irq1_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(l1_view & l1_mask)) |=> !irq_out1);
   assert_casc0_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (map_mask0 == '0) |-> !l0_view[CASC0_POS]);
   assert_casc1_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (map_mask1 == '0) |-> !l1_view[CASC1_POS]);

   for (genvar i = 0; i < TMR_N; i++) begin : g_tmr
      assert_tmr_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (tmr_pend[i] && !tmr_clr[i]) |=> tmr_pend[i]);
   end
endmodule

bind casc_irq_ctrl casc_irq_ctrl_chk #(
   .GRP_W     (GRP_W),
   .TMR_N     (TMR_N),
   .CASC0_POS (CASC0_POS),
   .CASC1_POS (CASC1_POS)
) u_chk (.*);

// File: tb/casc_irq_ctrl_test.sv
`timescale 1ns/1ps
module casc_irq_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  loc0_src = '0, loc1_src = '0, map_src = '0;
   logic [1:0]  tmr_src = '0;
   logic [5:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_out0, irq_out1;

   int n_chk = 0;
   int n_fail = 0;

   localparam logic [5:0] A_L0S = 6'h00, A_L0M = 6'h04, A_L1S = 6'h08, A_L1M = 6'h0C,
                          A_SHS = 6'h10, A_SMA = 6'h14, A_SMB = 6'h18, A_TMR = 6'h1C;

   always #2 clk = ~clk;

   casc_irq_ctrl uut (
      .clk, .rst_n, .loc0_src, .loc1_src, .map_src, .tmr_src,
      .bus_addr, .bus_wr, .bus_wdata, .bus_rdata, .irq_out0, .irq_out1
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic chk_rd(input string tag, input logic [5:0] a, input logic [31:0] exp);
      bus_addr = a;
      #1;
      check(tag, bus_rdata, exp);
   endtask

   task automatic t_reset();
      chk_rd("R1 l0 mask", A_L0M, 0);
      chk_rd("R1 l1 mask", A_L1M, 0);
      chk_rd("R1 mask A", A_SMA, 0);
      chk_rd("R1 mask B", A_SMB, 0);
      chk_rd("R1 timer", A_TMR, 0);
      check("R1 irq0", irq_out0, 0);
      check("R1 irq1", irq_out1, 0);
   endtask

   task automatic t_masks();
      logic [31:0] v;
      wr(A_L0M, 32'hFFFF_FFA5);
      chk_rd("R2 R11 l0 mask upper zero", A_L0M, 32'hA5);
      wr(A_L1M, 32'h3C);
      wr(A_SMA, 32'h0F);
      wr(A_SMB, 32'hF0);
      chk_rd("R11 l1 mask", A_L1M, 32'h3C);
      chk_rd("R11 mask A", A_SMA, 32'h0F);
      chk_rd("R11 mask B", A_SMB, 32'hF0);
      bus_addr = A_L0M; #1; v = bus_rdata;
      wr(A_L0M, v | 32'h40);
      chk_rd("R11 rmw", A_L0M, 32'hE5);
      wr(A_L0M, 0); wr(A_L1M, 0); wr(A_SMA, 0); wr(A_SMB, 0);
      chk_rd("R11 clear l0", A_L0M, 0);
      chk_rd("R11 clear B", A_SMB, 0);
   endtask

   task automatic t_local0();
      loc0_src = 8'h55;
      tick(3);
      chk_rd("R3 l0 status unmasked", A_L0S, 32'h55);
      check("R4 masked off", irq_out0, 0);
      loc0_src = 8'h00;
      wr(A_L0M, 32'h01);
      tick(3);
      loc0_src = 8'h01;
      @(posedge clk); @(posedge clk); @(negedge clk);
      chk_rd("R3 visible after two edges", A_L0S, 32'h01);
      check("R4 not yet", irq_out0, 0);
      tick(1);
      check("R4 one edge later", irq_out0, 1);
      loc0_src = 8'h55;
      wr(A_L0M, 32'hAA);
      tick(3);
      check("R4 disjoint mask", irq_out0, 0);
      loc0_src = 8'h80;
      wr(A_L0M, 32'h80);
      tick(4);
      chk_rd("R6 external bit7 ignored", A_L0S, 32'h00);
      check("R6 irq0 from external bit7", irq_out0, 0);
      loc0_src = 0;
      wr(A_L0M, 0);
   endtask

   task automatic t_local1();
      loc1_src = 8'hFF;
      tick(3);
      chk_rd("R7 R8 l1 overridden bits", A_L1S, 32'hF4);
      wr(A_L1M, 32'h10);
      tick(1);
      check("R5 irq1 on", irq_out1, 1);
      wr(A_L1M, 32'h0B);
      tick(1);
      check("R5 R8 overridden bits idle", irq_out1, 0);
      loc1_src = 0;
      wr(A_L1M, 0);
      tick(3);
   endtask

   task automatic t_shared();
      map_src = 8'h81;
      tick(3);
      chk_rd("R3 shared status", A_SHS, 32'h81);
      chk_rd("R6 casc0 masked", A_L0S, 32'h00);
      wr(A_SMA, 32'h01);
      chk_rd("R6 casc0 on", A_L0S, 32'h80);
      chk_rd("R7 casc1 stays off", A_L1S, 32'h00);
      wr(A_L0M, 32'h80);
      tick(1);
      check("R6 irq0 via cascade", irq_out0, 1);
      wr(A_SMB, 32'h80);
      wr(A_SMA, 32'h02);
      chk_rd("R6 casc0 off under A", A_L0S, 32'h00);
      chk_rd("R7 casc1 on under B", A_L1S, 32'h08);
      wr(A_L1M, 32'h08);
      tick(1);
      check("R7 irq1 via cascade", irq_out1, 1);
      check("R6 irq0 dropped", irq_out0, 0);
      wr(A_SMA, 0); wr(A_SMB, 0); wr(A_L0M, 0); wr(A_L1M, 0);
      map_src = 0;
      tick(3);
   endtask

   task automatic t_timer();
      tmr_src = 2'b01;
      tick(3);
      tmr_src = 2'b00;
      tick(5);
      chk_rd("R8 timer0 pending", A_TMR, 32'h1);
      chk_rd("R8 in l1 status", A_L1S, 32'h1);
      tick(10);
      chk_rd("R8 sticky", A_TMR, 32'h1);
      wr(A_TMR, 32'h2);
      chk_rd("R9 partial clear keeps other", A_TMR, 32'h1);
      wr(A_TMR, 32'h3);
      chk_rd("R9 both cleared", A_TMR, 32'h0);
      tmr_src = 2'b11;
      tick(5);
      chk_rd("R8 both pending", A_TMR, 32'h3);
      wr(A_L1M, 32'h03);
      tick(1);
      check("R8 irq1 from timers", irq_out1, 1);
      wr(A_TMR, 32'h3);
      tick(5);
      chk_rd("R9 held-high line no reset", A_TMR, 32'h0);
      check("R9 irq1 cleared", irq_out1, 0);
      tmr_src = 0;
      wr(A_L1M, 0);
      tick(3);
   endtask

   task automatic t_status_writes();
      wr(A_L0S, 32'hFF);
      wr(A_L1S, 32'hFF);
      wr(A_SHS, 32'hFF);
      chk_rd("R10 l0 status", A_L0S, 0);
      chk_rd("R10 shared status", A_SHS, 0);
      chk_rd("R10 l0 mask untouched", A_L0M, 0);
      chk_rd("R10 l1 mask untouched", A_L1M, 0);
      chk_rd("R10 mask A untouched", A_SMA, 0);
      wr(6'h24, 32'hFF);
      wr(6'h38, 32'hFF);
      chk_rd("R2 out of range read", 6'h24, 0);
      chk_rd("R2 top read", 6'h3C, 0);
      chk_rd("R2 mask B after stray write", A_SMB, 0);
      chk_rd("R2 mask A after stray write", A_SMA, 0);
   endtask

   initial begin
      #(4 * 100000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tick(2);
      t_reset();
      t_masks();
      t_local0();
      t_local1();
      t_shared();
      t_timer();
      t_status_writes();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule